// File: doc/BRIEF.md
# Instruction Queue Enqueue/Execute Controller

This block keeps the bookkeeping for one ring of instruction slots held in memory outside the block. A host programs the ring through a small register port: a base address, a capacity counted in groups of 40 slots, and two separate gates. The enqueue gate lets producers place new instructions. The execute gate lets queued instructions go to the execution side. Each accepted push is given a slot number, so the producer knows where to write the instruction. Each dispatch presents the slot number and its byte address to the consumer. A completion pulse comes back for every instruction that finishes.

The controller keeps an in-flight count of instructions that have been dispatched but not yet completed. Software uses it to drain the queue safely. It first clears the enqueue gate. It then waits until the in-flight count reads zero. Only then does it clear the execute gate. To bring the queue up, software sets the execute gate first and the enqueue gate second. One group of 40 slots is always held back, so usable depth is (groups − 1) × 40.

Both stream interfaces use valid/ready.

On the push side:
- A push transfers only on a cycle where `push_valid` and `push_ready` are both high.
- `push_ready` is low while the enqueue gate is clear, while the ring is full, or during a size write.
- A producer holding `push_valid` is back-pressured, not dropped.

On the dispatch side:
- `disp_valid` is high only while the execute gate is set and the queue holds an entry.
- `disp_slot` and `disp_addr` are stable while `disp_valid` waits for `disp_ready`.

Top module: `iq_ctrl`

## Requirements
- R1: After reset, both gates are clear, both slot pointers are zero and the in-flight count is zero. The size register holds the `SIZE_RST` parameter value and the base register holds zero.
- R2: The register port decodes four addresses. Address 0 is the base address. Address 1 is the group count, in bits [SIZE_W-1:0]. Usable depth is (groups − 1) × 40 entries. With a group count of 0 or 1, no push is accepted.
- R3: `q_full` is high exactly when the number of queued entries equals the usable depth. While full, `push_ready` is low. A push held valid is accepted later, at the next free slot.
- R4: Address 2 bit 0 is the enqueue gate. `push_ready` is high only while this gate is set.
- R5: Address 3 bit 0 is the execute gate. `disp_valid` is high only while this gate is set and at least one entry is queued. Entries leave in push order.
- R6: Push and dispatch slot numbers count up from 0. They wrap to 0 after slot groups × 40 − 1.
- R7: Base address bits [6:0] always read as zero. `disp_addr` equals base + `disp_slot` × 64.
- R8: The in-flight count reads from address 3 bits [16+CNT_W-1:16]. It rises by one on each dispatch handshake and falls by one on each `done_pulse`. A dispatch and a completion in the same cycle leave it unchanged. A completion while it is zero is ignored. Dispatch is held off while the count is at its maximum.
- R9: A write to address 2 changes only the enqueue gate. A write to address 3 changes only the execute gate, and the in-flight field ignores writes. A read-modify-write of one gate therefore leaves every other field unchanged.
- R10: A write to address 1 clears both pointers and the queued-entry count on the next edge. No push or dispatch handshake is offered in the cycle of that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr` (combinational) |
| push_valid | input | 1 | Producer offers an instruction |
| push_ready | output | 1 | Controller accepts the push |
| push_slot | output | PTR_W | Slot the next accepted push occupies |
| disp_valid | output | 1 | A queued instruction is offered to execution |
| disp_ready | input | 1 | Execution side takes it |
| disp_slot | output | PTR_W | Slot of the offered instruction |
| disp_addr | output | 64 | Byte address of the offered instruction |
| done_pulse | input | 1 | One instruction completed |
| q_full | output | 1 | Queued entries equal usable depth |

## Verification
The assertions check four properties on every cycle:
- each handshake side respects its gate;
- the queued count never exceeds the usable depth;
- the ring refuses pushes while full or shallow;
- the in-flight count takes single steps and never wraps below zero.

Other behaviours appear only across the bench's scenarios:
- ordering and wrap of slot numbers;
- address arithmetic from the aligned base;
- the field isolation of read-modify-write;
- pointer clearing on a size change;
- the drain sequence that polls in-flight to zero.

A behavioural reference model checks these on every clock.

// File: rtl/iq_ctrl_pkg.sv
package iq_ctrl_pkg;
  localparam int GRP_ENTRIES = 40;
  localparam int SLOT_BYTES_LG = 6;
  localparam int BASE_ALIGN_LG = 7;
  localparam int INFL_LSB = 16;

  typedef enum logic [1:0] {
    RA_BASE = 2'd0,
    RA_SIZE = 2'd1,
    RA_CTL  = 2'd2,
    RA_PROG = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/iq_regs.sv
module iq_regs
  import iq_ctrl_pkg::*;
#(
  parameter int SIZE_W = 8,
  parameter int SIZE_RST = 2,
  parameter int CNT_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [63:0]       reg_wdata,
  input  logic [CNT_W-1:0]  infl,
  output logic [63:0]       reg_rdata,
  output logic [63:0]       base,
  output logic [SIZE_W-1:0] size,
  output logic              enq_en,
  output logic              exec_en,
  output logic              size_wr
);
  reg_addr_e ra;
  assign ra = reg_addr_e'(reg_addr);
  assign size_wr = reg_wr && (ra == RA_SIZE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base    <= '0;
      size    <= SIZE_W'(SIZE_RST);
      enq_en  <= 1'b0;
      exec_en <= 1'b0;
    end else if (reg_wr) begin
      case (ra)
        RA_BASE: base    <= {reg_wdata[63:BASE_ALIGN_LG], {BASE_ALIGN_LG{1'b0}}};
        RA_SIZE: size    <= reg_wdata[SIZE_W-1:0];
        RA_CTL:  enq_en  <= reg_wdata[0];
        RA_PROG: exec_en <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (ra)
      RA_BASE: reg_rdata = base;
      RA_SIZE: reg_rdata = 64'(size);
      RA_CTL:  reg_rdata = {63'd0, enq_en};
      RA_PROG: reg_rdata = (64'(infl) << INFL_LSB) | {63'd0, exec_en};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/iq_ptrs.sv
module iq_ptrs
  import iq_ctrl_pkg::*;
#(
  parameter int SIZE_W = 8,
  parameter int PTR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIZE_W-1:0] size,
  input  logic              enq_en,
  input  logic              exec_en,
  input  logic              size_wr,
  input  logic              infl_full,
  input  logic              push_valid,
  input  logic              disp_ready,
  output logic              push_ready,
  output logic              disp_valid,
  output logic [PTR_W-1:0]  push_slot,
  output logic [PTR_W-1:0]  disp_slot,
  output logic [PTR_W-1:0]  occ,
  output logic [PTR_W-1:0]  depth,
  output logic              q_full,
  output logic              disp_fire
);
  logic [PTR_W-1:0] ring;
  logic             push_fire;

  assign ring  = PTR_W'(size) * PTR_W'(GRP_ENTRIES);
  assign depth = (size == '0) ? '0 : ring - PTR_W'(GRP_ENTRIES);

  assign q_full     = (occ == depth);
  assign push_ready = enq_en && !q_full && !size_wr;
  assign disp_valid = exec_en && (occ != '0) && !infl_full && !size_wr;
  assign push_fire  = push_valid && push_ready;
  assign disp_fire  = disp_valid && disp_ready;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p,
                                            input logic [PTR_W-1:0] lim);
    return (p + PTR_W'(1) == lim) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || size_wr) begin
      push_slot <= '0;
      disp_slot <= '0;
      occ       <= '0;
    end else begin
      if (push_fire) push_slot <= bump(push_slot, ring);
      if (disp_fire) disp_slot <= bump(disp_slot, ring);
      case ({push_fire, disp_fire})
        2'b10:   occ <= occ + PTR_W'(1);
        2'b01:   occ <= occ - PTR_W'(1);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/iq_inflight.sv
module iq_inflight #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_fire,
  input  logic             done_pulse,
  output logic [CNT_W-1:0] infl,
  output logic             infl_full
);
  assign infl_full = &infl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      infl <= '0;
    end else if (disp_fire && !done_pulse) begin
      infl <= infl + CNT_W'(1);
    end else if (!disp_fire && done_pulse && infl != '0) begin
      infl <= infl - CNT_W'(1);
    end
  end
endmodule

// File: rtl/iq_ctrl.sv
module iq_ctrl
  import iq_ctrl_pkg::*;
#(
  parameter int SIZE_W = 8,
  parameter int SIZE_RST = 2,
  localparam int PTR_W = $clog2((2 ** SIZE_W) * GRP_ENTRIES),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [63:0]      reg_wdata,
  output logic [63:0]      reg_rdata,
  input  logic             push_valid,
  output logic             push_ready,
  output logic [PTR_W-1:0] push_slot,
  output logic             disp_valid,
  input  logic             disp_ready,
  output logic [PTR_W-1:0] disp_slot,
  output logic [63:0]      disp_addr,
  input  logic             done_pulse,
  output logic             q_full
);
  logic [63:0]       base;
  logic [SIZE_W-1:0] size;
  logic              enq_en, exec_en, size_wr;
  logic [CNT_W-1:0]  infl;
  logic              infl_full, disp_fire;
  logic [PTR_W-1:0]  occ, depth;

  iq_regs #(.SIZE_W(SIZE_W), .SIZE_RST(SIZE_RST), .CNT_W(CNT_W)) u_regs (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .infl,
    .reg_rdata, .base, .size, .enq_en, .exec_en, .size_wr
  );

  iq_ptrs #(.SIZE_W(SIZE_W), .PTR_W(PTR_W)) u_ptrs (
    .clk, .rst_n, .size, .enq_en, .exec_en, .size_wr, .infl_full,
    .push_valid, .disp_ready, .push_ready, .disp_valid, .push_slot,
    .disp_slot, .occ, .depth, .q_full, .disp_fire
  );

  iq_inflight #(.CNT_W(CNT_W)) u_infl (
    .clk, .rst_n, .disp_fire, .done_pulse, .infl, .infl_full
  );

  assign disp_addr = base + (64'(disp_slot) << SLOT_BYTES_LG);
endmodule

// File: rtl/iq_ctrl_chk.sv
module iq_ctrl_chk #(
  parameter int PTR_W = 14,
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_ready,
  input logic             disp_valid,
  input logic             disp_ready,
  input logic             done_pulse,
  input logic             q_full,
  input logic             enq_en,
  input logic             exec_en,
  input logic [PTR_W-1:0] occ,
  input logic [PTR_W-1:0] depth,
  input logic [CNT_W-1:0] infl
);
  AST_PUSH_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    push_ready |-> enq_en); // R4
  AST_DISP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (exec_en && occ != '0)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= depth); // R3
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !push_ready); // R3
  AST_SHALLOW_RING: assert property (@(posedge clk) disable iff (!rst_n)
    (depth == '0) |-> !push_ready); // R2
  AST_INFL_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready && !done_pulse) |=> infl == $past(infl) + CNT_W'(1)); // R8
  AST_INFL_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && !(disp_valid && disp_ready) && infl != '0) |=> infl == $past(infl) - CNT_W'(1)); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && !(disp_valid && disp_ready) && infl == '0) |=> infl == '0); // R8
endmodule

bind iq_ctrl iq_ctrl_chk #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_ready(push_ready), .disp_valid(disp_valid),
  .disp_ready(disp_ready), .done_pulse(done_pulse), .q_full(q_full),
  .enq_en(enq_en), .exec_en(exec_en), .occ(occ), .depth(depth), .infl(infl)
);

// File: tb/iq_ctrl_tb_top.sv
module iq_ctrl_tb_top;
  localparam int SIZE_W = 8;
  localparam int SIZE_RST = 2;
  localparam int PTR_W = $clog2((2 ** SIZE_W) * 40);
  localparam int CNT_W = PTR_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic push_valid = 1'b0, push_ready;
  logic [PTR_W-1:0] push_slot, disp_slot;
  logic disp_valid, disp_ready = 1'b0;
  logic [63:0] disp_addr;
  logic done_pulse = 1'b0;
  logic q_full;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // behavioural reference state
  longint m_base = 0;
  int m_size = SIZE_RST, m_wr = 0, m_rd = 0, m_occ = 0, m_infl = 0;
  bit m_enq = 0, m_exec = 0;

  always #2.5 clk = ~clk;

  iq_ctrl #(.SIZE_W(SIZE_W), .SIZE_RST(SIZE_RST)) dut_i (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .push_valid, .push_ready, .push_slot, .disp_valid, .disp_ready,
    .disp_slot, .disp_addr, .done_pulse, .q_full
  );

  function automatic int m_depth();
    return (m_size == 0) ? 0 : (m_size - 1) * 40;
  endfunction
  function automatic bit m_sizewr();
    return reg_wr && reg_addr == 2'd1;
  endfunction
  function automatic bit m_pready();
    return m_enq && m_occ < m_depth() && !m_sizewr();
  endfunction
  function automatic bit m_dvalid();
    return m_exec && m_occ != 0 && m_infl != (2 ** CNT_W - 1) && !m_sizewr();
  endfunction
  function automatic longint m_rdata();
    case (reg_addr)
      2'd0: return m_base;
      2'd1: return longint'(m_size);
      2'd2: return longint'(m_enq);
      default: return (longint'(m_infl) << 16) | longint'(m_exec);
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_base = 0; m_size = SIZE_RST; m_wr = 0; m_rd = 0; m_occ = 0;
      m_infl = 0; m_enq = 0; m_exec = 0;
    end else begin
      bit pf, df;
      int ring;
      pf = m_pready() && push_valid;
      df = m_dvalid() && disp_ready;
      ring = m_size * 40;
      if (m_sizewr()) begin
        m_wr = 0; m_rd = 0; m_occ = 0;
      end else begin
        if (pf) begin m_wr = (m_wr + 1 == ring) ? 0 : m_wr + 1; m_occ++; end
        if (df) begin m_rd = (m_rd + 1 == ring) ? 0 : m_rd + 1; m_occ--; end
      end
      if (df && !done_pulse) m_infl++;
      else if (!df && done_pulse && m_infl > 0) m_infl--;
      if (reg_wr) begin
        case (reg_addr)
          2'd0: m_base = longint'(reg_wdata) & ~longint'(127);
          2'd1: m_size = int'(reg_wdata[SIZE_W-1:0]);
          2'd2: m_enq = reg_wdata[0];
          default: m_exec = reg_wdata[0];
        endcase
      end
    end
  end

  // every-cycle comparison, 1 ns after inputs change at the falling edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      check(push_ready == m_pready(), "R4 push_ready", push_ready, m_pready());
      check(disp_valid == m_dvalid(), "R5 disp_valid", disp_valid, m_dvalid());
      check(q_full == (m_occ == m_depth()), "R3 q_full", q_full, m_occ == m_depth());
      check(int'(push_slot) == m_wr, "R6 push_slot", push_slot, m_wr);
      check(int'(disp_slot) == m_rd, "R6 disp_slot", disp_slot, m_rd);
      check(disp_addr == m_base + (longint'(m_rd) << 6), "R7 disp_addr",
            disp_addr, m_base + (longint'(m_rd) << 6));
      check(reg_rdata == m_rdata(), "R9 reg_rdata", reg_rdata, m_rdata());
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(input logic [1:0] a, input longint d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask
  task automatic rd(input logic [1:0] a, output longint d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic report();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    finished = 1;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
  end

  initial begin
    longint v, pv;
    cyc(3);
    rst_n = 1'b1;
    // R1 reset values
    rd(2'd0, v); check(v == 0, "R1 base", v, 0);
    rd(2'd1, v); check(v == SIZE_RST, "R1 size", v, SIZE_RST);
    rd(2'd2, v); check(v == 0, "R1 enq", v, 0);
    rd(2'd3, v); check(v == 0, "R1 prog", v, 0);
    check(push_slot == 0 && disp_slot == 0, "R1 pointers", push_slot, 0);
    // R4 gate closed: pushes refused
    push_valid = 1'b1;
    cyc(3);
    check(push_ready == 0 && push_slot == 0, "R4 refused", push_slot, 0);
    // R7 base alignment
    wr(2'd0, 64'h1234_5678_9ABC_DEFF);
    rd(2'd0, v); check(v == 64'h1234_5678_9ABC_DE80, "R7 base align", v, 64'h1234_5678_9ABC_DE80);
    // R3 fill to depth 40 with execute gate closed
    wr(2'd2, 1);
    cyc(45);
    check(q_full == 1 && push_ready == 0, "R3 full stall", q_full, 1);
    check(push_slot == 40, "R2 depth 40", push_slot, 40);
    // R5 bring up execute; consumer stalls first
    wr(2'd3, 1);
    cyc(2);
    check(disp_valid == 1 && disp_slot == 0, "R5 valid held", disp_slot, 0);
    check(disp_addr == 64'h1234_5678_9ABC_DE80, "R7 addr slot0", disp_addr, 64'h1234_5678_9ABC_DE80);
    disp_ready = 1'b1;
    cyc(150);            // continuous flow wraps ring of 80 slots (R6)
    push_valid = 1'b0;
    cyc(50);
    check(disp_valid == 0, "R5 drained", disp_valid, 0);
    rd(2'd3, pv);
    check((pv >> 16) == m_infl && m_infl > 0, "R8 inflight", pv >> 16, m_infl);
    // R9 read-modify-write clearing execute keeps inflight and enqueue gate
    wr(2'd3, pv & ~longint'(1));
    rd(2'd3, v); check(v == (pv & ~longint'(1)), "R9 prog rmw", v, pv & ~longint'(1));
    rd(2'd2, v); check(v == 1, "R9 enq kept", v, 1);
    wr(2'd2, 64'hFFFF_FFFF_FFFF_FFF0);
    rd(2'd3, v); check(v == (pv & ~longint'(1)), "R9 ctl write isolated", v, pv & ~longint'(1));
    wr(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(2'd3, v); check((v >> 16) == (pv >> 16), "R9 inflight read-only", v >> 16, pv >> 16);
    // R8 completion and dispatch together keep inflight unchanged
    wr(2'd2, 1);
    push_valid = 1'b1; done_pulse = 1'b1;
    cyc(20);
    push_valid = 1'b0;
    cyc(5);
    done_pulse = 1'b0;
    rd(2'd3, v); check((v >> 16) == m_infl, "R8 paired", v >> 16, m_infl);
    // R8 drain to zero, then extra completions ignored
    done_pulse = 1'b1;
    cyc(m_infl + 4);
    done_pulse = 1'b0;
    rd(2'd3, v); check((v >> 16) == 0, "R8 no underflow", v >> 16, 0);
    // R10 size change clears pointers; R2 new depth 80
    wr(2'd3, 0);
    wr(2'd1, 3);
    check(push_slot == 0 && disp_slot == 0, "R10 cleared", push_slot, 0);
    push_valid = 1'b1;
    cyc(90);
    check(push_slot == 80 && q_full == 1, "R2 depth 80", push_slot, 80);
    // R2 one group leaves no usable depth
    wr(2'd1, 1);
    cyc(3);
    check(push_ready == 0 && push_slot == 0, "R2 size one", push_ready, 0);
    wr(2'd1, 0);
    cyc(3);
    check(push_ready == 0, "R2 size zero", push_ready, 0);
    push_valid = 1'b0;
    cyc(2);
    finished = 1;
    report();
  end
endmodule